// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block turns a 32-bit linear address into a 32-bit physical address. The page number (the upper 20 bits) is mapped to a physical frame through a page table that lives in memory and holds one 4-byte entry per page. A base register, loaded through a write strobe, selects which process's table is active. The low 12 bits of the address are a byte offset within a 4 KiB page and pass through unchanged.

A 4-slot fully associative translation cache is checked before any memory traffic. A hit answers without touching memory. A miss walks the table with exactly one word read, tests the entry's present flag, and returns either a physical address or a fault. Valid mappings are cached. Faults are not. Writing the base register invalidates every cached mapping, so translations from the previous table cannot leak into the new one.

The controller has five named states:
- IDLE: ready for a request.
- LOOKUP: the cache is probed. On a hit the controller answers and returns to IDLE. On a miss it moves to READ_REQ.
- READ_REQ: one memory read is issued, then the controller moves to WAIT_RESP.
- WAIT_RESP: the controller waits for the read data, then moves to DONE.
- DONE: the walked result is presented, then the controller returns to IDLE.

Only one request is in progress at a time.

Top module: `page_xlate_unit`

## Requirements
- R1: `rsp_paddr[11:0]` equals `req_laddr[11:0]` of the request being answered, whenever the response is not a fault.
- R2: On a cache miss, exactly one memory read is issued. Its byte address is `base + page*4`, where `page = req_laddr[31:12]` and `base` is the base register value at acceptance.
- R3: A table entry carries the frame number in bits 31:12 and the present flag in bit 0. Bits 11:1 are ignored. A valid translation is `{frame, offset}`.
- R4: If the fetched entry has bit 0 clear, the response has `rsp_fault`=1 and `rsp_paddr`=0.
- R5: A cache hit raises `rsp_valid` in the cycle after acceptance. It issues no memory read and gives the same address as the walk that filled the slot.
- R6: A successful walk fills the lowest-numbered invalid slot. When all slots are valid, it replaces the slot named by a 2-bit round-robin pointer. The pointer starts at 0 and advances only on such a replacement.
- R7: A faulting lookup is never cached, so the same page walks memory again.
- R8: A write to the base register invalidates all cache slots in the same clock edge. A later lookup of any page walks the newly selected table.
- R9: A request in flight when the base register is written completes with the base it was accepted with. Its result is not cached.
- R10: `req_ready` is high only in IDLE. It stays low from acceptance through the response cycle.
- R11: On a miss, `mem_req` is a one-cycle pulse two cycles after acceptance. `rsp_valid` rises in the cycle after the cycle in which `mem_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Unit can accept a request |
| req_laddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Entry not present |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base byte address |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry word |

## Verification
The bench fills all four slots and then forces two evictions. A wrong victim choice or a pointer that advances on plain fills would show up as an unexpected memory read, or as a missing one. A non-present page is requested twice. A unit that cached faults would answer the second request from the cache and issue no read. The base register is written while a walk is underway. A design that let the new base reach the pending read would fetch the wrong entry, and one that cached the stale mapping would answer the next request for that page without walking the new table. Entry bits 11:1 are set to non-zero values in memory, so a unit that leaked them into the address would return a wrong result.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_READ_REQ,
        ST_WAIT_RESP,
        ST_DONE
    } pxu_state_e;

    localparam int PTE_SHIFT = 2;  // 4-byte table entries
endpackage

// File: rtl/pxu_tcache.sv
module pxu_tcache #(
    parameter int PAGE_W  = 20,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              lk_hit,
    output logic [PAGE_W-1:0] lk_frame,
    input  logic              fill_en,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic [PAGE_W-1:0] fill_frame,
    input  logic              flush
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [PAGE_W-1:0]  key_q [ENTRIES];
    logic [PAGE_W-1:0]  val_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   victim;
    logic               free_found;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = valid_q[g] && (key_q[g] == lk_page);
        end
    endgenerate

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_frame = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_frame = lk_frame | val_q[i];
        end
    end

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        victim = free_found ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[victim] <= 1'b1;
            if (!free_found) rr_q <= rr_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            key_q[victim] <= fill_page;
            val_q[victim] <= fill_frame;
        end
    end

    // R6
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/pxu_walk_ctrl.sv
module pxu_walk_ctrl
    import pxu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_laddr,
    output logic                    rsp_valid,
    output logic [ADDR_W-1:0]       rsp_paddr,
    output logic                    rsp_fault,
    input  logic [ADDR_W-1:0]       base_reg,
    input  logic                    base_we,
    output logic [ADDR_W-OFF_W-1:0] lk_page,
    input  logic                    lk_hit,
    input  logic [ADDR_W-OFF_W-1:0] lk_frame,
    output logic                    fill_en,
    output logic [ADDR_W-OFF_W-1:0] fill_page,
    output logic [ADDR_W-OFF_W-1:0] fill_frame,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_rvalid,
    input  logic [ADDR_W-1:0]       mem_rdata
);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int PAD_W  = ADDR_W - PAGE_W - PTE_SHIFT;

    pxu_state_e        state_q, state_d;
    logic [ADDR_W-1:0] laddr_q;
    logic [ADDR_W-1:0] base_q;
    logic [PAGE_W-1:0] frame_q;
    logic              fault_q;
    logic              stale_q;
    logic              accept;
    logic              present;

    assign accept  = req_valid && req_ready;
    assign present = mem_rdata[0];
    assign lk_page = laddr_q[ADDR_W-1:OFF_W];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:    state_d = lk_hit ? ST_IDLE : ST_READ_REQ;
            ST_READ_REQ:  state_d = ST_WAIT_RESP;
            ST_WAIT_RESP: if (mem_rvalid) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q <= '0;
            base_q  <= '0;
            frame_q <= '0;
            fault_q <= 1'b0;
            stale_q <= 1'b0;
        end else begin
            if (accept) begin
                laddr_q <= req_laddr;
                base_q  <= base_reg;
                stale_q <= base_we;
            end else if (base_we) begin
                stale_q <= 1'b1;
            end
            if (state_q == ST_WAIT_RESP && mem_rvalid) begin
                frame_q <= mem_rdata[ADDR_W-1:OFF_W];
                fault_q <= !present;
            end
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        rsp_fault  = 1'b0;
        rsp_paddr  = '0;
        mem_req    = 1'b0;
        fill_en    = 1'b0;
        mem_addr   = base_q + {{PAD_W{1'b0}}, laddr_q[ADDR_W-1:OFF_W], {PTE_SHIFT{1'b0}}};
        fill_page  = laddr_q[ADDR_W-1:OFF_W];
        fill_frame = mem_rdata[ADDR_W-1:OFF_W];
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_LOOKUP: begin
                if (lk_hit) begin
                    rsp_valid = 1'b1;
                    rsp_paddr = {lk_frame, laddr_q[OFF_W-1:0]};
                end
            end
            ST_READ_REQ:  mem_req = 1'b1;
            ST_WAIT_RESP: fill_en = mem_rvalid && present && !stale_q && !base_we;
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_fault = fault_q;
                rsp_paddr = fault_q ? '0 : {frame_q, laddr_q[OFF_W-1:0]};
            end
            default: ;
        endcase
    end

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R11
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R4
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R3
    entry_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> !$isunknown(mem_rdata));
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] base_reg;
    logic [PAGE_W-1:0] lk_page, lk_frame, fill_page, fill_frame;
    logic              lk_hit, fill_en;

    always_ff @(posedge clk) begin
        if (!rst_n)       base_reg <= '0;
        else if (base_we) base_reg <= base_wdata;
    end

    pxu_tcache #(.PAGE_W(PAGE_W), .ENTRIES(ENTRIES)) u_tcache (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_page    (lk_page),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .fill_en    (fill_en),
        .fill_page  (fill_page),
        .fill_frame (fill_frame),
        .flush      (base_we)
    );

    pxu_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_laddr  (req_laddr),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .base_reg   (base_reg),
        .base_we    (base_we),
        .lk_page    (lk_page),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .fill_en    (fill_en),
        .fill_page  (fill_page),
        .fill_frame (fill_frame),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );
endmodule

// File: tb/page_xlate_unit_tb.sv
module page_xlate_unit_tb_top;
    localparam logic [31:0] BASE_A = 32'h0040_0000;
    localparam logic [31:0] BASE_B = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_req;
    logic [31:0] rsp_paddr, mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int          tests = 0;
    int          fails = 0;
    int          mem_reads = 0;
    logic [31:0] last_addr = '0;
    logic [1:0]  mcnt = '0;

    always #5 clk = ~clk;

    page_xlate_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .base_we(base_we), .base_wdata(base_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Table contents: frame derived from address; present unless page low bits are 3;
    // bits 11:1 deliberately non-zero.
    function automatic logic [31:0] table_word(input logic [31:0] a);
        logic [19:0] fr;
        fr = a[21:2] * 20'd7 + {a[25:22], 16'h0000};
        return {fr, 11'h2AA, (a[4:2] != 3'd3)};
    endfunction

    always @(posedge clk) begin
        if (mem_req) begin
            mem_reads <= mem_reads + 1;
            last_addr <= mem_addr;
            mcnt      <= 2'd2;
        end else if (mcnt != 0) begin
            mcnt <= mcnt - 2'd1;
        end
    end
    assign mem_rvalid = (mcnt == 2'd1);
    assign mem_rdata  = mem_rvalid ? table_word(last_addr) : 32'h0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] la, output logic [31:0] pa,
                          output logic flt, output int lat);
        bit ready_ok;
        ready_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_laddr = la;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) ready_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (req_ready) ready_ok = 1'b0;
        pa = rsp_paddr; flt = rsp_fault;
        chk(ready_ok, "R10 ready low while busy", 32'(ready_ok), 32'd1);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after response", 32'(req_ready), 32'd1);
    endtask

    function automatic logic [31:0] exp_pa(input logic [31:0] base, input logic [31:0] la);
        logic [31:0] w;
        w = table_word(base + {10'b0, la[31:12], 2'b00});
        return {w[31:12], la[11:0]};
    endfunction

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(mem_req == 1'b0, "R11 reset mem_req", 32'(mem_req), 32'd0);
    endtask

    // Miss then hit on same page
    task automatic t_miss_hit();
        logic [31:0] pa; logic f; int lat, r0;
        r0 = mem_reads;
        do_req(32'h0000_5123, pa, f, lat);
        chk(lat == 5, "R11 miss latency", 32'(lat), 32'd5);
        chk(mem_reads - r0 == 1, "R2 one read per miss", 32'(mem_reads - r0), 32'd1);
        chk(last_addr == BASE_A + 32'h14, "R2 entry address", last_addr, BASE_A + 32'h14);
        chk(pa == exp_pa(BASE_A, 32'h0000_5123) && !f, "R3 walked address", pa, exp_pa(BASE_A, 32'h0000_5123));
        chk(pa[11:0] == 12'h123, "R1 offset passthrough", pa, 32'h123);
        r0 = mem_reads;
        do_req(32'h0000_5FFF, pa, f, lat);
        chk(lat == 1, "R5 hit latency", 32'(lat), 32'd1);
        chk(mem_reads == r0, "R5 hit no read", 32'(mem_reads - r0), 32'd0);
        chk(pa == exp_pa(BASE_A, 32'h0000_5FFF), "R5 hit address", pa, exp_pa(BASE_A, 32'h0000_5FFF));
    endtask

    task automatic t_fault();
        logic [31:0] pa; logic f; int lat, r0;
        do_req(32'h0000_3ABC, pa, f, lat);
        chk(f == 1'b1, "R4 fault flag", 32'(f), 32'd1);
        chk(pa == 32'h0, "R4 fault address", pa, 32'h0);
        r0 = mem_reads;
        do_req(32'h0000_3ABC, pa, f, lat);
        chk(mem_reads - r0 == 1 && f, "R7 fault not cached", 32'(mem_reads - r0), 32'd1);
    endtask

    task automatic expect_reads(input logic [31:0] la, input logic [31:0] base,
                                input int n, input string tag);
        logic [31:0] pa; logic f; int lat, r0;
        r0 = mem_reads;
        do_req(la, pa, f, lat);
        chk(mem_reads - r0 == n, tag, 32'(mem_reads - r0), 32'(n));
        chk(pa == exp_pa(base, la) && !f, tag, pa, exp_pa(base, la));
    endtask

    task automatic t_replace();
        set_base(BASE_A);  // flushes page 5
        expect_reads(32'h0000_5000, BASE_A, 1, "R8 flush forces walk");
        expect_reads(32'h0001_0004, BASE_A, 1, "R6 fill slot1");
        expect_reads(32'h0001_1008, BASE_A, 1, "R6 fill slot2");
        expect_reads(32'h0001_200C, BASE_A, 1, "R6 fill slot3");
        expect_reads(32'h0001_4010, BASE_A, 1, "R6 evict slot0");
        expect_reads(32'h0001_0020, BASE_A, 0, "R6 survivor hit");
        expect_reads(32'h0001_4030, BASE_A, 0, "R6 new entry hit");
        expect_reads(32'h0000_5040, BASE_A, 1, "R6 evicted page walks");
        expect_reads(32'h0001_1050, BASE_A, 0, "R6 slot2 kept");
        expect_reads(32'h0001_0060, BASE_A, 1, "R6 pointer advanced");
    endtask

    task automatic t_base_switch();
        set_base(BASE_B);
        expect_reads(32'h0001_4070, BASE_B, 1, "R8 new table walked");
        chk(last_addr == BASE_B + 32'h50, "R2 entry address new base", last_addr, BASE_B + 32'h50);
    endtask

    task automatic t_inflight();
        logic [31:0] pa; logic f; int lat;
        fork
            do_req(32'h0002_1777, pa, f, lat);
            begin
                @(negedge clk); @(negedge clk);
                base_we = 1'b1; base_wdata = BASE_A;
                @(negedge clk);
                base_we = 1'b0;
            end
        join
        chk(last_addr == BASE_B + 32'h84, "R9 old base used", last_addr, BASE_B + 32'h84);
        chk(pa == exp_pa(BASE_B, 32'h0002_1777), "R9 old table result", pa, exp_pa(BASE_B, 32'h0002_1777));
        expect_reads(32'h0002_1777, BASE_A, 1, "R9 result not cached");
        chk(last_addr == BASE_A + 32'h84, "R9 new base walked", last_addr, BASE_A + 32'h84);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        set_base(BASE_A);
        t_miss_hit();
        t_fault();
        t_replace();
        t_base_switch();
        t_inflight();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule